// File: doc/BRIEF.md
# DMA descriptor address sequencer

This block generates the address stream for one DMA channel. A single load strobe captures a descriptor's control word along with its starting source address, destination address and byte count. The block then steps through the transfer one beat at a time. For each beat it offers a source address, a destination address and a beat size to a data mover through a valid/ready handshake.

The source pointer can count up, count down, or stay fixed. The fixed case is buffer-fill mode, where the same fill data is written to every destination beat. The destination pointer can count up, or stay at one address with a 1-, 2- or 4-byte access width. In the fixed case, the address and count bits below that width are cleared when the descriptor is loaded. A traffic-class value, a source coherency flag and a snoop-not-required flag are held with the descriptor and driven out for the bus logic to use. The traffic class only matters on bus transactions; memory-to-memory transfers do not use it. A control word with a reserved encoding raises an error flag and issues no beats.

Top module: `dma_addr_seq`

## Requirements
- R1: While rst_ni is low and after it rises, the block is idle: beat_valid_o=0, done_o=0, err_o=0, tc_o=0, src_coh_o=0, snoop_nr_o=1.
- R2: A descriptor is accepted on a rising clock edge where load_i=1 and beat_valid_o=0. A load_i pulse while beats are pending is ignored and leaves every output unchanged apart from the normal beat progress. Control word fields: [1:0] source mode, [3:2] destination mode, [5:4] granularity, [6] source coherency, [7] destination coherency, [10:8] traffic class.
- R3: Source mode 0 adds the beat size to the source address after each beat, mode 1 subtracts it, and mode 2 keeps the source address fixed.
- R4: Destination mode 0 adds the beat size to the destination address after each beat; mode 1 keeps it constant.
- R5: In destination mode 1, granularity 0 selects 1 byte and 1 selects 2 bytes, with address and count bit 0 cleared. Granularity 2 selects 4 bytes, with bits 1:0 cleared. In destination mode 0 the granularity field has no effect, including the value 3.
- R6: The beat size is the granularity in destination mode 1 and 4 otherwise, capped at the remaining count. Each handshake reduces the remaining count by the beat size.
- R7: While beat_valid_o=1 and beat_ready_i=0, the beat outputs hold. A beat completes on a clock edge where both are 1.
- R8: done_o pulses for one cycle after the edge that completes the final beat. A descriptor whose count is zero after clearing pulses done_o after its load edge and issues no beats.
- R9: Source mode 3, destination mode 2 or 3, or granularity 3 in destination mode 1 sets err_o and issues no beats or done pulse. err_o stays set until the next accepted descriptor.
- R10: After a load, tc_o shows the traffic class, src_coh_o shows the source coherency bit, and snoop_nr_o shows the inverse of the destination coherency bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Descriptor load strobe |
| ctrl_i | input | 11 | Descriptor control word |
| src_addr_i | input | AW | Starting source address |
| dst_addr_i | input | AW | Starting destination address |
| count_i | input | CW | Transfer byte count |
| beat_valid_o | output | 1 | Beat offered to data mover |
| beat_ready_i | input | 1 | Data mover accepts beat |
| beat_src_o | output | AW | Beat source address |
| beat_dst_o | output | AW | Beat destination address |
| beat_size_o | output | 3 | Beat size in bytes |
| tc_o | output | 3 | Traffic class |
| src_coh_o | output | 1 | Source coherency attribute |
| snoop_nr_o | output | 1 | Snoop-not-required attribute |
| done_o | output | 1 | Transfer complete pulse |
| err_o | output | 1 | Reserved encoding flag |

## Verification
Every result appears one edge after its cause. The load edge sets beat_valid_o, err_o, the first beat's addresses, the attributes, or the zero-count done pulse. Each handshake edge advances the beat outputs, or lowers valid and pulses done_o after the final beat. The bench changes inputs on the falling edge. It compares the outputs at that falling edge against a model that advances once per beat accepted at the previous rising edge, so each check looks exactly one edge after the stimulus that caused it. Random ready stalls and ignored loads during a transfer also confirm that nothing moves without a handshake.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int CTRL_W   = 11;
  localparam int SRC_LSB  = 0;
  localparam int DST_LSB  = 2;
  localparam int GRAN_LSB = 4;
  localparam int SCOH_BIT = 6;
  localparam int DCOH_BIT = 7;
  localparam int TC_LSB   = 8;

  typedef enum logic [1:0] {
    PTR_INC  = 2'd0,
    PTR_DEC  = 2'd1,
    PTR_HOLD = 2'd2
  } ptr_op_e;
endpackage

// File: rtl/dma_seq_dec.sv
module dma_seq_dec
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [AW-1:0]     dst_addr_i,
  input  logic [CW-1:0]     count_i,
  output logic              cfg_err_o,
  output ptr_op_e           src_op_o,
  output ptr_op_e           dst_op_o,
  output logic [2:0]        unit_o,
  output logic [AW-1:0]     dst_addr_o,
  output logic [CW-1:0]     count_o,
  output logic [2:0]        tc_o,
  output logic              src_coh_o,
  output logic              dst_coh_o
);
  logic [1:0] src_f, dst_f, gran_f, low_mask;
  logic       dst_const;

  assign src_f     = ctrl_i[SRC_LSB +: 2];
  assign dst_f     = ctrl_i[DST_LSB +: 2];
  assign gran_f    = ctrl_i[GRAN_LSB +: 2];
  assign dst_const = (dst_f == 2'b01);
  assign tc_o      = ctrl_i[TC_LSB +: 3];
  assign src_coh_o = ctrl_i[SCOH_BIT];
  assign dst_coh_o = ctrl_i[DCOH_BIT];

  always_comb begin
    unit_o   = 3'd4;
    low_mask = 2'b00;
    if (dst_const) begin
      case (gran_f)
        2'b00:   unit_o = 3'd1;
        2'b01:   begin unit_o = 3'd2; low_mask = 2'b01; end
        2'b10:   begin unit_o = 3'd4; low_mask = 2'b11; end
        default: unit_o = 3'd4;
      endcase
    end
  end

  always_comb begin
    case (src_f)
      2'b01:   src_op_o = PTR_DEC;
      2'b10:   src_op_o = PTR_HOLD;
      default: src_op_o = PTR_INC;
    endcase
  end

  assign dst_op_o   = dst_const ? PTR_HOLD : PTR_INC;
  assign cfg_err_o  = (src_f == 2'b11) || dst_f[1] || (dst_const && gran_f == 2'b11);
  assign dst_addr_o = {dst_addr_i[AW-1:2], dst_addr_i[1:0] & ~low_mask};
  assign count_o    = {count_i[CW-1:2], count_i[1:0] & ~low_mask};
endmodule

// File: rtl/dma_seq_ptr.sv
module dma_seq_ptr
  import dma_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  ptr_op_e       load_op_i,
  input  logic          adv_i,
  input  logic [2:0]    step_i,
  output logic [AW-1:0] ptr_o
);
  ptr_op_e op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
      op_q  <= PTR_INC;
    end else if (load_i) begin
      ptr_o <= load_val_i;
      op_q  <= load_op_i;
    end else if (adv_i) begin
      case (op_q)
        PTR_INC: ptr_o <= ptr_o + AW'(step_i);
        PTR_DEC: ptr_o <= ptr_o - AW'(step_i);
        default: ptr_o <= ptr_o;
      endcase
    end
  end

  a_r7_ptr_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> $stable(ptr_o));
  a_r3_ptr_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && op_q == PTR_HOLD) |=> $stable(ptr_o));
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [AW-1:0]     src_addr_i,
  input  logic [AW-1:0]     dst_addr_i,
  input  logic [CW-1:0]     count_i,
  output logic              beat_valid_o,
  input  logic              beat_ready_i,
  output logic [AW-1:0]     beat_src_o,
  output logic [AW-1:0]     beat_dst_o,
  output logic [2:0]        beat_size_o,
  output logic [2:0]        tc_o,
  output logic              src_coh_o,
  output logic              snoop_nr_o,
  output logic              done_o,
  output logic              err_o
);
  logic          busy_q, done_q, err_q, dst_const_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    unit_q, tc_q;
  logic          scoh_q, dcoh_q;

  logic          cfg_err, d_scoh, d_dcoh;
  ptr_op_e       d_src_op, d_dst_op;
  logic [2:0]    d_unit, d_tc;
  logic [AW-1:0] d_dst;
  logic [CW-1:0] d_cnt;

  logic          accept, fire;
  logic [CW-1:0] unit_ext, size_ext;

  dma_seq_dec #(.AW(AW), .CW(CW)) dec_i (
    .ctrl_i     (ctrl_i),
    .dst_addr_i (dst_addr_i),
    .count_i    (count_i),
    .cfg_err_o  (cfg_err),
    .src_op_o   (d_src_op),
    .dst_op_o   (d_dst_op),
    .unit_o     (d_unit),
    .dst_addr_o (d_dst),
    .count_o    (d_cnt),
    .tc_o       (d_tc),
    .src_coh_o  (d_scoh),
    .dst_coh_o  (d_dcoh)
  );

  assign accept   = load_i && !busy_q;
  assign fire     = busy_q && beat_ready_i;
  assign unit_ext = CW'(unit_q);
  assign size_ext = (cnt_q < unit_ext) ? cnt_q : unit_ext;

  dma_seq_ptr #(.AW(AW)) src_ptr_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (src_addr_i),
    .load_op_i  (d_src_op),
    .adv_i      (fire),
    .step_i     (beat_size_o),
    .ptr_o      (beat_src_o)
  );

  dma_seq_ptr #(.AW(AW)) dst_ptr_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (d_dst),
    .load_op_i  (d_dst_op),
    .adv_i      (fire),
    .step_i     (beat_size_o),
    .ptr_o      (beat_dst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      dst_const_q <= 1'b0;
      cnt_q       <= '0;
      unit_q      <= '0;
      tc_q        <= '0;
      scoh_q      <= 1'b0;
      dcoh_q      <= 1'b0;
    end else if (accept) begin
      err_q       <= cfg_err;
      busy_q      <= !cfg_err && (d_cnt != '0);
      done_q      <= !cfg_err && (d_cnt == '0);
      dst_const_q <= (d_dst_op == PTR_HOLD);
      cnt_q       <= d_cnt;
      unit_q      <= d_unit;
      tc_q        <= d_tc;
      scoh_q      <= d_scoh;
      dcoh_q      <= d_dcoh;
    end else begin
      done_q <= 1'b0;
      if (fire) begin
        cnt_q <= cnt_q - size_ext;
        if (cnt_q == size_ext) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign beat_valid_o = busy_q;
  assign beat_size_o  = size_ext[2:0];
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign tc_o         = tc_q;
  assign src_coh_o    = scoh_q;
  assign snoop_nr_o   = !dcoh_q;

  a_r7_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && !beat_ready_i) |=> (beat_valid_o && $stable(beat_src_o)
      && $stable(beat_dst_o) && $stable(beat_size_o)));
  a_r6_size_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> (beat_size_o != 3'd0 && CW'(beat_size_o) <= cnt_q));
  a_r9_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!beat_valid_o && !done_o));
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> !done_o);
  a_r2_attr_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && load_i) |=> ($stable(tc_o) && $stable(snoop_nr_o) && $stable(src_coh_o)));
  a_r5_dst_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && dst_const_q && unit_q == 3'd4) |-> beat_dst_o[1:0] == 2'b00);
endmodule

// File: tb/dma_addr_seq_tb_top.sv
module dma_addr_seq_tb_top;
  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_i = 1'b0;
  logic [10:0]   ctrl_i = '0;
  logic [AW-1:0] src_addr_i = '0;
  logic [AW-1:0] dst_addr_i = '0;
  logic [CW-1:0] count_i = '0;
  logic          beat_ready_i = 1'b0;
  logic          beat_valid_o, src_coh_o, snoop_nr_o, done_o, err_o;
  logic [AW-1:0] beat_src_o, beat_dst_o;
  logic [2:0]    beat_size_o, tc_o;

  int n_checks = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_addr_seq #(.AW(AW), .CW(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .ctrl_i(ctrl_i),
    .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i), .count_i(count_i),
    .beat_valid_o(beat_valid_o), .beat_ready_i(beat_ready_i),
    .beat_src_o(beat_src_o), .beat_dst_o(beat_dst_o), .beat_size_o(beat_size_o),
    .tc_o(tc_o), .src_coh_o(src_coh_o), .snoop_nr_o(snoop_nr_o),
    .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] mk_ctrl(int s, int d, int g, bit sc, bit dc, int tc);
    return {tc[2:0], dc, sc, g[1:0], d[1:0], s[1:0]};
  endfunction

  function automatic bit exp_err(logic [10:0] c);
    return (c[1:0] == 2'b11) || c[3] || (c[3:2] == 2'b01 && c[5:4] == 2'b11);
  endfunction

  function automatic logic [1:0] exp_mask(logic [10:0] c);
    if (c[3:2] != 2'b01) return 2'b00;
    case (c[5:4])
      2'b01:   return 2'b01;
      2'b10:   return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic int exp_unit(logic [10:0] c);
    if (c[3:2] != 2'b01) return 4;
    case (c[5:4])
      2'b00:   return 1;
      2'b01:   return 2;
      default: return 4;
    endcase
  endfunction

  // Run one descriptor; rnd_ready stalls randomly, poke issues loads while busy
  task automatic run_desc(logic [10:0] c, logic [31:0] s, logic [31:0] d,
                          logic [15:0] n, bit rnd_ready, bit poke);
    logic [31:0] es, ed;
    logic [15:0] rem;
    int unit, sz;
    bit rdy;
    @(negedge clk);
    ctrl_i = c; src_addr_i = s; dst_addr_i = d; count_i = n; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    es  = s;
    ed  = {d[31:2], d[1:0] & ~exp_mask(c)};
    rem = {n[15:2], n[1:0] & ~exp_mask(c)};
    unit = exp_unit(c);
    chk("R10 tc", 64'(tc_o), 64'(c[10:8]));
    chk("R10 snoop_nr", 64'(snoop_nr_o), 64'(!c[7]));
    chk("R10 src_coh", 64'(src_coh_o), 64'(c[6]));
    if (exp_err(c)) begin
      chk("R9 err set", 64'(err_o), 64'd1);
      repeat (2) begin
        chk("R9 no beats", 64'(beat_valid_o), 64'd0);
        chk("R9 no done", 64'(done_o), 64'd0);
        @(negedge clk);
      end
      return;
    end
    chk("R9 err clear", 64'(err_o), 64'd0);
    if (rem == 16'd0) begin
      chk("R8 zero count done", 64'(done_o), 64'd1);
      chk("R8 zero count no beats", 64'(beat_valid_o), 64'd0);
      @(negedge clk);
      chk("R8 done one cycle", 64'(done_o), 64'd0);
      return;
    end
    while (rem != 16'd0) begin
      sz = (int'(rem) < unit) ? int'(rem) : unit;
      chk("R7 valid", 64'(beat_valid_o), 64'd1);
      chk("R3 src addr", 64'(beat_src_o), 64'(es));
      chk("R4 dst addr", 64'(beat_dst_o), 64'(ed));
      chk("R6 size", 64'(beat_size_o), 64'(sz));
      chk("R8 no early done", 64'(done_o), 64'd0);
      rdy = rnd_ready ? ($urandom % 3 != 0) : 1'b1;
      beat_ready_i = rdy;
      if (poke) begin
        load_i = ($urandom % 2 == 1);
        ctrl_i = mk_ctrl(0, 0, 0, !c[6], !c[7], int'(~c[10:8]));
        src_addr_i = ~s; dst_addr_i = ~d; count_i = 16'd0;
      end
      @(negedge clk);
      load_i = 1'b0;
      beat_ready_i = 1'b0;
      if (poke) begin
        chk("R2 tc locked", 64'(tc_o), 64'(c[10:8]));
        chk("R2 snoop locked", 64'(snoop_nr_o), 64'(!c[7]));
      end
      if (rdy) begin
        rem = rem - 16'(sz);
        case (c[1:0])
          2'b00:   es = es + 32'(sz);
          2'b01:   es = es - 32'(sz);
          default: es = es;
        endcase
        if (c[3:2] == 2'b00) ed = ed + 32'(sz);
      end
    end
    chk("R8 done after last", 64'(done_o), 64'd1);
    chk("R8 idle after last", 64'(beat_valid_o), 64'd0);
    @(negedge clk);
    chk("R8 done one cycle", 64'(done_o), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++; n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 64'(beat_valid_o), 64'd0);
    chk("R1 reset snoop_nr", 64'(snoop_nr_o), 64'd1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 idle valid", 64'(beat_valid_o), 64'd0);
    chk("R1 idle done", 64'(done_o), 64'd0);
    chk("R1 idle err", 64'(err_o), 64'd0);
    chk("R1 idle tc", 64'(tc_o), 64'd0);
    chk("R1 idle src_coh", 64'(src_coh_o), 64'd0);
    chk("R1 idle snoop_nr", 64'(snoop_nr_o), 64'd1);

    // directed corners
    run_desc(mk_ctrl(0, 0, 0, 1, 1, 5), 32'h100, 32'h203, 16'd10, 0, 0); // R3 R4 R6
    run_desc(mk_ctrl(1, 0, 0, 0, 0, 2), 32'h400, 32'h800, 16'd9, 1, 1);  // R3 dec, R2
    run_desc(mk_ctrl(2, 1, 0, 0, 1, 1), 32'h55, 32'h1003, 16'd3, 1, 0);  // R3 fill, R5 1B
    run_desc(mk_ctrl(0, 1, 1, 1, 0, 7), 32'h10, 32'h2001, 16'd7, 0, 0);  // R5 2B mask
    run_desc(mk_ctrl(0, 1, 2, 0, 0, 0), 32'h10, 32'h3002, 16'd3, 0, 0);  // R5/R8 masked to 0
    run_desc(mk_ctrl(0, 0, 3, 0, 0, 3), 32'h10, 32'h3001, 16'd5, 0, 0);  // R5 gran ignored
    run_desc(mk_ctrl(0, 0, 0, 0, 0, 0), 32'h10, 32'h20, 16'd0, 0, 0);    // R8 zero
    run_desc(mk_ctrl(3, 0, 0, 0, 0, 0), 32'h10, 32'h20, 16'd8, 0, 0);    // R9 src
    run_desc(mk_ctrl(0, 2, 0, 0, 0, 0), 32'h10, 32'h20, 16'd8, 0, 0);    // R9 dst
    run_desc(mk_ctrl(0, 1, 3, 0, 0, 0), 32'h10, 32'h20, 16'd8, 0, 0);    // R9 gran
    run_desc(mk_ctrl(1, 1, 2, 1, 1, 6), 32'h0, 32'h7, 16'd13, 1, 1);    // R9 cleared, wrap

    for (int i = 0; i < 120; i++) begin
      int sm, dm, gm;
      sm = ($urandom % 12 == 0) ? 3 : int'($urandom % 3);
      dm = ($urandom % 12 == 0) ? 2 + int'($urandom % 2) : int'($urandom % 2);
      gm = ($urandom % 10 == 0) ? 3 : int'($urandom % 3);
      run_desc(mk_ctrl(sm, dm, gm, 1'($urandom), 1'($urandom), int'($urandom % 8)),
               $urandom, $urandom, 16'($urandom % 40), 1'($urandom), 1'($urandom));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule